// File: doc/BRIEF.md
# Multimode Flyback Gate Timing Controller

This block produces the gate-drive pulse train for a primary-side flyback converter. A compensator upstream supplies a digital power demand word. The block turns that word into switching events in one of three regimes. Two regimes track the demand continuously. The third works in packets of pulses. At high demand the controller regulates on-time and turns the switch on at a ringing valley of the auxiliary winding. At medium demand it holds on-time at the minimum and sets power by the switching period. At low demand it issues a counted packet of minimum pulses once per line half-cycle.

The inputs are the demand word, a one-clock valley pulse from the auxiliary-winding comparator and a one-clock strobe at each line half-cycle. The outputs are the gate signal and a 2-bit regime indicator. All times are counted in clock cycles. All limits, thresholds and counts are runtime configuration inputs. The minimum on-time can therefore follow the input voltage.

Top module: `flyback_mode_pwm`

## Requirements
- R1: While reset is asserted (synchronous, active low), and after it is released, `gate_drv` is low and `mode_ind` reads 0 (no regime yet) until the first pulse.
- R2: When `enable` is low, `gate_drv` goes low at the next clock edge and no new pulse starts.
- R3: `mode_ind` encodes the regime of the current switching cycle: 1 = burst, 2 = frequency, 3 = valley. The internal regime target moves burst→frequency when demand ≥ `cfg_thr_lo_up`, frequency→burst when demand < `cfg_thr_lo_dn`, frequency→valley when demand ≥ `cfg_thr_hi_up`, and valley→frequency when demand < `cfg_thr_hi_dn`. A demand between a pair of thresholds keeps the current regime.
- R4: In frequency regime, each pulse lasts `cfg_ton_min` clocks. The rising-edge spacing is `cfg_per_max` − demand, bounded below by `cfg_per_min`.
- R5: In valley regime, the on-time is `cfg_ton_min` + (demand − `cfg_thr_hi_dn`), limited to `cfg_ton_max`.
- R6: In valley regime, the switch turns on at the clock edge that samples a `zcd_pulse`, provided the gate is already off and at least `cfg_per_min` clocks have passed since the last turn-on. A valley pulse during the on-time or inside the minimum period is ignored, and a later valley is used.
- R7: In valley regime, if no qualified valley pulse arrives, turn-on is forced once `cfg_valley_to` clocks have passed since the end of the on-time.
- R8: In burst regime, each `line_strobe` loads a pulse budget of demand limited to the range [`cfg_burst_min`, `cfg_burst_cap`]. The block issues that many pulses of `cfg_ton_min` clocks, spaced `cfg_per_max` clocks apart, and issues none once the budget is spent.
- R9: `mode_ind` changes only on the clock edge at which a pulse starts.
- R10: On-time and period are captured at turn-on. A demand change during a pulse does not alter the width of that pulse.
- R11: No pulse is longer than `cfg_ton_max`, and successive rising edges are at least `cfg_per_min` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Switching enable; low forces the gate off |
| demand | input | DEM_W | Power demand word from the compensator |
| zcd_pulse | input | 1 | One-clock valley marker from the auxiliary winding |
| line_strobe | input | 1 | One-clock marker at each line half-cycle |
| cfg_ton_min | input | CNT_W | Minimum on-time, clocks |
| cfg_ton_max | input | CNT_W | Maximum on-time, clocks |
| cfg_per_min | input | CNT_W | Minimum switching period, clocks |
| cfg_per_max | input | CNT_W | Maximum switching period, clocks |
| cfg_valley_to | input | CNT_W | Valley wait limit after on-time, clocks |
| cfg_thr_lo_dn | input | DEM_W | Frequency→burst threshold |
| cfg_thr_lo_up | input | DEM_W | Burst→frequency threshold |
| cfg_thr_hi_dn | input | DEM_W | Valley→frequency threshold |
| cfg_thr_hi_up | input | DEM_W | Frequency→valley threshold |
| cfg_burst_min | input | PCNT_W | Minimum pulses per burst |
| cfg_burst_cap | input | PCNT_W | Maximum pulses per burst |
| gate_drv | output | 1 | Gate drive |
| mode_ind | output | 2 | Regime indicator (0 none, 1 burst, 2 frequency, 3 valley) |

## Verification
On every cycle the assertions check four things. The gate must drop after `enable` falls. The indicator must change only when a pulse starts, and it must be nonzero while the gate is high. No pulse may exceed the on-time ceiling, and no two rising edges may be closer than the minimum period. The bench scenarios show the rest. They cover the exact widths and periods in each regime, the hysteresis bands, which valley pulse is honoured and when the valley wait expires. They also cover the pulse count of each burst and the capture of demand at turn-on.

// File: rtl/flyback_pkg.sv
// Shared types for the multimode flyback gate timing controller.
// Assumes nothing beyond a 2-bit regime code seen at the top-level port.
package flyback_pkg;

    // Regime code; the values are visible on the mode indicator port.
    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_BURST  = 2'd1,
        MODE_FREQ   = 2'd2,
        MODE_VALLEY = 2'd3
    } mode_e;

endpackage

// File: rtl/fb_regime_sel.sv
// Regime target selection with two hysteresis bands on the demand word.
// Moves at most one regime per clock. Assumes lo_dn <= lo_up <= hi_dn <= hi_up.
module fb_regime_sel
    import flyback_pkg::*;
#(
    parameter int DEM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEM_W-1:0] demand,
    input  logic [DEM_W-1:0] thr_lo_dn,
    input  logic [DEM_W-1:0] thr_lo_up,
    input  logic [DEM_W-1:0] thr_hi_dn,
    input  logic [DEM_W-1:0] thr_hi_up,
    output mode_e            target_o
);

    mode_e target_q;

    // Step the target regime along the hysteresis ladder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= MODE_BURST;
        end else begin
            unique case (target_q)
                MODE_BURST: begin
                    if (demand >= thr_lo_up) target_q <= MODE_FREQ;
                end
                MODE_FREQ: begin
                    if (demand >= thr_hi_up)     target_q <= MODE_VALLEY;
                    else if (demand < thr_lo_dn) target_q <= MODE_BURST;
                end
                MODE_VALLEY: begin
                    if (demand < thr_hi_dn) target_q <= MODE_FREQ;
                end
                default: target_q <= MODE_BURST;
            endcase
        end
    end

    assign target_o = target_q;

endmodule

// File: rtl/fb_cycle_plan.sv
// Combinational planner: derives the on-time, period bound and burst budget
// that the next switching cycle would use under the current target regime.
// Assumes CNT_W >= DEM_W and DEM_W >= PCNT_W.
module fb_cycle_plan
    import flyback_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DEM_W  = 12,
    parameter int PCNT_W = 8
) (
    input  mode_e             target,
    input  logic [DEM_W-1:0]  demand,
    input  logic [DEM_W-1:0]  thr_hi_dn,
    input  logic [CNT_W-1:0]  ton_min,
    input  logic [CNT_W-1:0]  ton_max,
    input  logic [CNT_W-1:0]  per_min,
    input  logic [CNT_W-1:0]  per_max,
    input  logic [PCNT_W-1:0] burst_min,
    input  logic [PCNT_W-1:0] burst_cap,
    output logic [CNT_W-1:0]  ton_n,
    output logic [CNT_W-1:0]  per_n,
    output logic [PCNT_W-1:0] burst_n
);

    localparam int EW = CNT_W + 1;

    logic [CNT_W-1:0]  dem_ext;
    logic [DEM_W-1:0]  dem_over;
    logic [EW-1:0]     ton_sum;
    logic [CNT_W-1:0]  ton_valley;
    logic [CNT_W-1:0]  per_raw;
    logic [CNT_W-1:0]  per_freq;
    logic [CNT_W-1:0]  per_slow;
    logic [PCNT_W-1:0] burst_capped;

    // On-time for valley regime: excess over the lower valley threshold.
    always_comb begin
        dem_over   = (demand > thr_hi_dn) ? (demand - thr_hi_dn) : '0;
        ton_sum    = {1'b0, ton_min} + EW'(dem_over);
        ton_valley = (ton_sum > {1'b0, ton_max}) ? ton_max : ton_sum[CNT_W-1:0];
    end

    // Period for frequency regime: shrinks as demand grows, floored at the minimum.
    always_comb begin
        dem_ext  = CNT_W'(demand);
        per_raw  = (per_max > dem_ext) ? (per_max - dem_ext) : '0;
        per_freq = (per_raw < per_min) ? per_min : per_raw;
        per_slow = (per_max < per_min) ? per_min : per_max;
    end

    // Burst budget: demand limited to the programmed pulse-count window.
    always_comb begin
        burst_capped = (demand > DEM_W'(burst_cap)) ? burst_cap : demand[PCNT_W-1:0];
        burst_n      = (burst_capped < burst_min) ? burst_min : burst_capped;
    end

    // Select the plan for the target regime.
    always_comb begin
        unique case (target)
            MODE_VALLEY: begin ton_n = ton_valley; per_n = per_min;  end
            MODE_FREQ:   begin ton_n = ton_min;    per_n = per_freq; end
            default:     begin ton_n = ton_min;    per_n = per_slow; end
        endcase
    end

endmodule

// File: rtl/fb_burst_budget.sv
// Pulse budget for burst regime: loaded at each line half-cycle strobe and
// decremented by each pulse started in burst regime. A strobe wins over a
// decrement in the same cycle. Outside burst regime a strobe clears it.
module fb_burst_budget
    import flyback_pkg::*;
#(
    parameter int PCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              line_strobe,
    input  mode_e             target,
    input  logic              start,
    input  logic [PCNT_W-1:0] burst_n,
    output logic              avail_o
);

    logic [PCNT_W-1:0] left_q;

    // Maintain the remaining pulse count of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            left_q <= '0;
        end else if (line_strobe) begin
            left_q <= (target == MODE_BURST) ? burst_n : '0;
        end else if (start && target == MODE_BURST && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign avail_o = (left_q != '0);

endmodule

// File: rtl/fb_switch_timer.sv
// Switching-cycle timer. It runs one counter from each turn-on, drives the gate
// for the captured on-time, and decides the next turn-on from the target regime.
// Valley pulses are qualified against the gate state and the minimum period.
// Assumes ton_n >= 1. The counter saturates while idle.
module fb_switch_timer
    import flyback_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  mode_e            target,
    input  logic [CNT_W-1:0] ton_n,
    input  logic [CNT_W-1:0] per_n,
    input  logic [CNT_W-1:0] per_min,
    input  logic [CNT_W-1:0] valley_to,
    input  logic             zcd,
    input  logic             burst_avail,
    output logic             start_o,
    output logic             gate_o,
    output mode_e            mode_o
);

    localparam int               EW      = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] ton_q;
    logic [CNT_W-1:0] per_q;
    logic             gate_q;
    mode_e            mode_q;

    logic [EW-1:0] elapsed;
    logic          gate_off;
    logic          min_ok;
    logic          valley_late;
    logic          start;

    // Decide whether the next clock edge begins a new switching cycle.
    always_comb begin
        elapsed     = {1'b0, cyc_q} + EW'(1);
        gate_off    = (cyc_q >= ton_q);
        min_ok      = (elapsed >= {1'b0, per_min});
        valley_late = (elapsed >= ({1'b0, ton_q} + {1'b0, valley_to}));
        unique case (target)
            MODE_VALLEY: start = gate_off && min_ok && (zcd || valley_late);
            MODE_FREQ:   start = gate_off && min_ok && (elapsed >= {1'b0, per_q});
            MODE_BURST:  start = gate_off && min_ok && (elapsed >= {1'b0, per_q}) && burst_avail;
            default:     start = 1'b0;
        endcase
        start = start && enable;
    end

    // Cycle counter: cleared at turn-on, saturating otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cyc_q <= CNT_TOP;
        end else if (start) begin
            cyc_q <= '0;
        end else if (cyc_q != CNT_TOP) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Capture on-time, period bound and regime at each turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ton_q  <= '0;
            per_q  <= '0;
            mode_q <= MODE_NONE;
        end else if (start) begin
            ton_q  <= ton_n;
            per_q  <= per_n;
            mode_q <= target;
        end
    end

    // Gate drive: high for exactly the captured on-time.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            gate_q <= 1'b0;
        end else if (start) begin
            gate_q <= 1'b1;
        end else if (gate_q && elapsed >= {1'b0, ton_q}) begin
            gate_q <= 1'b0;
        end
    end

    assign start_o = start;
    assign gate_o  = gate_q;
    assign mode_o  = mode_q;

endmodule

// File: rtl/flyback_mode_pwm.sv
// Top level of the multimode flyback gate timing controller. It chains the
// regime selector, the cycle planner, the burst budget and the switching timer.
// All configuration inputs are expected to be quasi-static.
module flyback_mode_pwm
    import flyback_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DEM_W  = 12,
    parameter int PCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DEM_W-1:0]  demand,
    input  logic              zcd_pulse,
    input  logic              line_strobe,
    input  logic [CNT_W-1:0]  cfg_ton_min,
    input  logic [CNT_W-1:0]  cfg_ton_max,
    input  logic [CNT_W-1:0]  cfg_per_min,
    input  logic [CNT_W-1:0]  cfg_per_max,
    input  logic [CNT_W-1:0]  cfg_valley_to,
    input  logic [DEM_W-1:0]  cfg_thr_lo_dn,
    input  logic [DEM_W-1:0]  cfg_thr_lo_up,
    input  logic [DEM_W-1:0]  cfg_thr_hi_dn,
    input  logic [DEM_W-1:0]  cfg_thr_hi_up,
    input  logic [PCNT_W-1:0] cfg_burst_min,
    input  logic [PCNT_W-1:0] cfg_burst_cap,
    output logic              gate_drv,
    output logic [1:0]        mode_ind
);

    mode_e             target;
    mode_e             mode_cur;
    logic [CNT_W-1:0]  ton_n;
    logic [CNT_W-1:0]  per_n;
    logic [PCNT_W-1:0] burst_n;
    logic              burst_avail;
    logic              start;

    fb_regime_sel #(.DEM_W(DEM_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .demand    (demand),
        .thr_lo_dn (cfg_thr_lo_dn),
        .thr_lo_up (cfg_thr_lo_up),
        .thr_hi_dn (cfg_thr_hi_dn),
        .thr_hi_up (cfg_thr_hi_up),
        .target_o  (target)
    );

    fb_cycle_plan #(.CNT_W(CNT_W), .DEM_W(DEM_W), .PCNT_W(PCNT_W)) u_plan (
        .target    (target),
        .demand    (demand),
        .thr_hi_dn (cfg_thr_hi_dn),
        .ton_min   (cfg_ton_min),
        .ton_max   (cfg_ton_max),
        .per_min   (cfg_per_min),
        .per_max   (cfg_per_max),
        .burst_min (cfg_burst_min),
        .burst_cap (cfg_burst_cap),
        .ton_n     (ton_n),
        .per_n     (per_n),
        .burst_n   (burst_n)
    );

    fb_burst_budget #(.PCNT_W(PCNT_W)) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .line_strobe (line_strobe),
        .target      (target),
        .start       (start),
        .burst_n     (burst_n),
        .avail_o     (burst_avail)
    );

    fb_switch_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .target      (target),
        .ton_n       (ton_n),
        .per_n       (per_n),
        .per_min     (cfg_per_min),
        .valley_to   (cfg_valley_to),
        .zcd         (zcd_pulse),
        .burst_avail (burst_avail),
        .start_o     (start),
        .gate_o      (gate_drv),
        .mode_o      (mode_cur)
    );

    assign mode_ind = mode_cur;

endmodule

// File: rtl/flyback_mode_pwm_chk.sv
// Assertion checker for the flyback gate timing controller, bound to the top.
// It tracks the high run length and the rising-edge spacing with its own counters.
module flyback_mode_pwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             gate_drv,
    input logic [1:0]       mode_ind,
    input logic [CNT_W-1:0] cfg_ton_max,
    input logic [CNT_W-1:0] cfg_per_min
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic             gate_d;
    logic [CNT_W-1:0] hi_run;
    logic [CNT_W-1:0] since_rise;
    logic             rise;

    assign rise = gate_drv && !gate_d;

    // Track previous gate, high run length and clocks since the last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_d     <= 1'b0;
            hi_run     <= '0;
            since_rise <= TOP;
        end else begin
            gate_d     <= gate_drv;
            hi_run     <= gate_drv ? ((hi_run == TOP) ? TOP : hi_run + 1'b1) : '0;
            since_rise <= rise ? CNT_W'(1) : ((since_rise == TOP) ? TOP : since_rise + 1'b1);
        end
    end

    // R2
    gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate_drv);

    // R11
    ontime_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_drv |-> (hi_run < cfg_ton_max));

    // R11
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (since_rise >= cfg_per_min));

    // R9
    mode_moves_at_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |-> $stable(mode_ind));

    // R3
    mode_valid_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_drv |-> (mode_ind != 2'd0));

endmodule

bind flyback_mode_pwm flyback_mode_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .gate_drv    (gate_drv),
    .mode_ind    (mode_ind),
    .cfg_ton_max (cfg_ton_max),
    .cfg_per_min (cfg_per_min)
);

// File: tb/tb_flyback_mode_pwm.sv
// Directed bench for the flyback gate timing controller: one task per scenario.
module tb_flyback_mode_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int DEM_W  = 12;
    localparam int PCNT_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic [DEM_W-1:0]  demand = '0;
    logic              zcd_pulse = 1'b0;
    logic              line_strobe = 1'b0;
    logic [CNT_W-1:0]  cfg_ton_min = 16'd4;
    logic [CNT_W-1:0]  cfg_ton_max = 16'd20;
    logic [CNT_W-1:0]  cfg_per_min = 16'd30;
    logic [CNT_W-1:0]  cfg_per_max = 16'd200;
    logic [CNT_W-1:0]  cfg_valley_to = 16'd60;
    logic [DEM_W-1:0]  cfg_thr_lo_dn = 12'd40;
    logic [DEM_W-1:0]  cfg_thr_lo_up = 12'd50;
    logic [DEM_W-1:0]  cfg_thr_hi_dn = 12'd90;
    logic [DEM_W-1:0]  cfg_thr_hi_up = 12'd100;
    logic [PCNT_W-1:0] cfg_burst_min = 8'd3;
    logic [PCNT_W-1:0] cfg_burst_cap = 8'd10;
    logic              gate_drv;
    logic [1:0]        mode_ind;

    int n_checks = 0;
    int n_fail   = 0;

    flyback_mode_pwm #(.CNT_W(CNT_W), .DEM_W(DEM_W), .PCNT_W(PCNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .demand(demand),
        .zcd_pulse(zcd_pulse), .line_strobe(line_strobe),
        .cfg_ton_min(cfg_ton_min), .cfg_ton_max(cfg_ton_max),
        .cfg_per_min(cfg_per_min), .cfg_per_max(cfg_per_max),
        .cfg_valley_to(cfg_valley_to),
        .cfg_thr_lo_dn(cfg_thr_lo_dn), .cfg_thr_lo_up(cfg_thr_lo_up),
        .cfg_thr_hi_dn(cfg_thr_hi_dn), .cfg_thr_hi_up(cfg_thr_hi_up),
        .cfg_burst_min(cfg_burst_min), .cfg_burst_cap(cfg_burst_cap),
        .gate_drv(gate_drv), .mode_ind(mode_ind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Leave the current pulse, then stop at the first negedge with the gate high.
    task automatic wait_rise();
        int guard = 0;
        while (gate_drv && guard < 2000) begin @(negedge clk); guard++; end
        while (!gate_drv && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    // From a rise, measure the high width and the spacing to the next rise.
    task automatic measure(output int w, output int p);
        int c = 0;
        w = -1; p = -1;
        while (p < 0 && c < 2000) begin
            @(negedge clk); c++;
            if (!gate_drv && w < 0) w = c;
            if (gate_drv && w >= 0) p = c;
        end
    endtask

    task automatic count_rises(input int n, output int cnt, output int hi);
        logic prev = gate_drv;
        cnt = 0; hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate_drv) hi++;
            if (gate_drv && !prev) cnt++;
            prev = gate_drv;
        end
    endtask

    task automatic strobe_line();
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        check(gate_drv == 1'b0, "R1", "gate in reset", gate_drv, 0);
        check(mode_ind == 2'd0, "R1", "mode in reset", mode_ind, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(gate_drv == 1'b0, "R1", "gate after reset, disabled", gate_drv, 0);
        check(mode_ind == 2'd0, "R1", "mode before first pulse", mode_ind, 0);
    endtask

    // Frequency regime: width = ton_min, period = per_max - demand.
    task automatic test_freq(input int dem, input int exp_p, input string req);
        int w, p;
        demand = DEM_W'(dem);
        wait_rise(); wait_rise();
        measure(w, p);
        check(w == 4, "R4", "freq width", w, 4);
        check(p == exp_p, req, "freq period", p, exp_p);
        check(mode_ind == 2'd2, req, "freq mode code", mode_ind, 2);
    endtask

    // Valley regime cycle with scripted valley pulses at given cycle offsets.
    task automatic valley_run(input int zc1, input int zc2, input int exp_w,
                              input int exp_p, input int chg_c, input int chg_v,
                              input string req);
        int c = 0;
        int w = -1;
        int p = -1;
        wait_rise();
        while (p < 0 && c < 2000) begin
            if (c == chg_c) demand = DEM_W'(chg_v);
            zcd_pulse = (c == zc1 || c == zc2);
            @(negedge clk); c++;
            zcd_pulse = 1'b0;
            if (!gate_drv && w < 0) w = c;
            if (gate_drv && w >= 0) p = c;
        end
        check(w == exp_w, (chg_c >= 0) ? "R10" : "R5", "valley width", w, exp_w);
        check(p == exp_p, req, "valley period", p, exp_p);
        check(mode_ind == 2'd3, "R3", "valley mode code", mode_ind, 3);
    endtask

    task automatic test_valley();
        demand = 12'd100;
        wait_rise(); wait_rise();
        // R10: demand raised mid-pulse; this pulse keeps 4+10 = 14
        valley_run(40, -1, 14, 41, 2, 110, "R6");
        // R5: 4 + 20 = 24 clamps to ton_max 20
        valley_run(40, -1, 20, 41, -1, 0, "R6");
        // R3: 95 lies in the valley hold band; width 4 + 5
        demand = 12'd95;
        valley_run(40, -1, 9, 41, -1, 0, "R3");
        // R6: pulse at offset 20 is inside per_min, next valley at 45 used
        valley_run(20, 45, 9, 46, -1, 0, "R6");
        // R7: pulse during on-time ignored, forced at ton + valley_to = 69
        valley_run(5, -1, 9, 69, -1, 0, "R7");
    endtask

    task automatic test_burst();
        int cnt, hi;
        demand = 12'd6;
        repeat (400) @(negedge clk);
        count_rises(300, cnt, hi);
        check(cnt == 0, "R8", "burst pulses without budget", cnt, 0);
        check(mode_ind == 2'd2, "R9", "mode held until first burst pulse", mode_ind, 2);
        strobe_line();
        count_rises(1500, cnt, hi);
        check(cnt == 6, "R8", "burst pulses for demand 6", cnt, 6);
        check(hi == 24, "R8", "burst high clocks 6x4", hi, 24);
        check(mode_ind == 2'd1, "R9", "mode after first burst pulse", mode_ind, 1);
        demand = 12'd1;
        strobe_line();
        count_rises(1000, cnt, hi);
        check(cnt == 3, "R8", "burst floor at burst_min", cnt, 3);
        demand = 12'd30;
        strobe_line();
        count_rises(2200, cnt, hi);
        check(cnt == 10, "R8", "burst cap at burst_cap", cnt, 10);
        check(mode_ind == 2'd1, "R3", "demand 30 stays burst", mode_ind, 1);
    endtask

    task automatic test_enable();
        int cnt, hi;
        enable = 1'b0;
        demand = 12'd70;
        count_rises(400, cnt, hi);
        check(hi == 0, "R2", "gate high clocks while disabled", hi, 0);
        enable = 1'b1;
        count_rises(400, cnt, hi);
        check(cnt >= 2, "R2", "pulses resume after enable", cnt, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        enable = 1'b1;
        test_freq(70, 130, "R4");
        test_freq(95, 105, "R3");
        test_valley();
        test_freq(85, 115, "R3");
        test_burst();
        test_enable();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule